// File: doc/BRIEF.md
# Variable-Length Instruction Prefetch Queue

This block sits at the front of a CPU pipeline, between a 32-bit instruction memory port and the instruction decoder. It requests aligned words from memory whenever it has room for them, stores the returned bytes in a small circular buffer with halfword granularity, and presents the oldest complete instruction to the decoder. Instructions are one, two or three halfwords long. The length comes from the top bits of the first halfword, so the decoder always sees the instruction aligned to bit 47 of its input.

The memory request path is valid/ready. Once the block raises `mem_req_valid`, it holds the request and its address steady until `mem_req_ready` is seen. The only exception is the cycle in which a redirect arrives, which withdraws any pending request. Responses come back in request order, one per accepted request. They have no ready signal: the block only issues a request when the buffer already has space reserved for its data. The decoder path is also valid/ready. `dec_valid` does not depend on `dec_ready`, and an instruction is removed only in a cycle where both are high and no redirect is present.

A redirect (a taken branch or any other change of fetch address) empties the buffer. It also marks every request still in flight as stale, so its data is thrown away on return, and restarts fetching from the word that contains the target.

Top module: `insn_prefetch_queue`

## Requirements
- R1: After reset the buffer is empty and `dec_valid` is low. `dec_pc` equals `reset_vector` with bit 0 cleared. The first request goes to `reset_vector` with bits 1:0 cleared. If bit 1 of the vector is set, the lower halfword of the first response is dropped.
- R2: A request is raised only when at least 4 bytes of the 16-byte buffer are free, counting bytes held plus 4 bytes for every live outstanding request. It is also held back when MAX_OUT requests are already outstanding. Successive accepted addresses rise by 4 until a redirect.
- R3: While `mem_req_valid` is high and `mem_req_ready` is low, the next cycle keeps `mem_req_valid` high with the same `mem_req_addr`, unless `redirect_valid` is high in that next cycle.
- R4: Each live response writes 32 bits. `mem_rsp_data[15:0]` is the halfword at the lower address and `mem_rsp_data[31:16]` is the halfword at address +2.
- R5: The length comes from the first halfword `h`. If `h[15:14]` is not `11`, the instruction is 16 bits and `dec_len` = 0. If `h[15:13]` = `110`, it is 32 bits and `dec_len` = 1. If `h[15:13]` = `111`, it is 48 bits and `dec_len` = 2.
- R6: `dec_valid` is high only when the buffer holds at least as many halfwords as the oldest instruction needs. `dec_insn[47:32]` is the first halfword, `[31:16]` the second and `[15:0]` the third, and any halfword beyond the instruction's length reads as zero.
- R7: When `dec_valid`, `dec_ready` and not `redirect_valid` are all true, the instruction is removed and `dec_pc` advances by its length in bytes. `dec_ready` has no effect while `dec_valid` is low.
- R8: In a cycle with `redirect_valid`, no request is raised. In the next cycle the buffer is empty, `dec_valid` is low and `dec_pc` equals `redirect_addr` with bit 0 cleared. The next accepted request goes to `redirect_addr` with bits 1:0 cleared. With back-to-back redirects, the last one wins.
- R9: Responses to requests outstanding when a redirect occurs, and any response arriving in the redirect cycle, are discarded.
- R10: If the redirect target has bit 1 set, the lower halfword of the first live response after the redirect is discarded, and the first instruction starts at the target.
- R11: Bytes held plus bytes reserved never exceed 16. With no consumption after reset and an always-ready memory, exactly four requests are accepted.
- R12: With a memory that is always ready and answers the cycle after acceptance, a decoder that consumes a 16-bit instruction every cycle sees no cycle without `dec_valid` once the queue is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reset_vector | input | AW | Fetch address loaded at reset |
| redirect_valid | input | 1 | Flush the queue and restart fetching |
| redirect_addr | input | AW | New fetch target (halfword aligned) |
| mem_req_valid | output | 1 | Request for one 32-bit word |
| mem_req_ready | input | 1 | Memory accepts the request (low = wait state) |
| mem_req_addr | output | AW | Word-aligned request address |
| mem_rsp_valid | input | 1 | Returned word is present, in request order |
| mem_rsp_data | input | 32 | Returned word, lower address in low half |
| dec_valid | output | 1 | A complete instruction is on `dec_insn` |
| dec_ready | input | 1 | Decoder consumes the presented instruction |
| dec_insn | output | 48 | Instruction, first halfword in bits 47:32 |
| dec_len | output | 2 | Length code: 0 = 16, 1 = 32, 2 = 48 bits |
| dec_pc | output | AW | Address of the presented instruction |

## Verification
On every cycle the assertions check the space accounting: held plus reserved halfwords stay within capacity, stale counts never exceed outstanding counts, responses only arrive against an outstanding request, stalled requests stay steady, addresses step by a word, and the cycle after a redirect shows no valid instruction. Whether the right bytes reach the decoder can only be shown by the bench scenarios: halfword ordering inside a word, alignment across the three lengths, the dropped lower half after a misaligned target, the discarding of stale data, the exact count of four requests at full occupancy, and the absence of bubbles under zero-wait streaming.

// File: rtl/ipq_pkg.sv
package ipq_pkg;

  typedef enum logic [1:0] {
    LEN_16 = 2'd0,
    LEN_32 = 2'd1,
    LEN_48 = 2'd2
  } ilen_e;

  // Length class from the first halfword of an instruction.
  function automatic ilen_e classify(input logic [15:0] first_hw);
    if (first_hw[15:14] != 2'b11) return LEN_16;
    else if (!first_hw[13])       return LEN_32;
    return LEN_48;
  endfunction

  // Number of halfwords occupied by a length class.
  function automatic logic [1:0] hw_span(input ilen_e c);
    case (c)
      LEN_32:  return 2'd2;
      LEN_48:  return 2'd3;
      default: return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/ipq_len_decode.sv
module ipq_len_decode
  import ipq_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic [15:0]   h0,
  input  logic [15:0]   h1,
  input  logic [15:0]   h2,
  input  logic [CW-1:0] avail,
  output logic [1:0]    len,
  output logic [1:0]    need,
  output logic [47:0]   insn,
  output logic          valid
);

  ilen_e code;

  always_comb begin
    code  = classify(h0);
    len   = code;
    need  = hw_span(code);
    insn  = {h0,
             (code != LEN_16) ? h1 : 16'h0000,
             (code == LEN_48) ? h2 : 16'h0000};
    // avail != 0 keeps valid low on an empty buffer regardless of stale data
    valid = (avail != '0) && (avail >= CW'(need));
  end

endmodule

// File: rtl/ipq_hw_buffer.sv
module ipq_hw_buffer #(
  parameter int DEPTH_HW = 8,
  parameter int CW       = $clog2(DEPTH_HW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push_en,
  input  logic          push_skip_lo,
  input  logic [31:0]   push_data,
  input  logic          pop_en,
  input  logic [1:0]    pop_hw,
  output logic [CW-1:0] count,
  output logic [15:0]   h0,
  output logic [15:0]   h1,
  output logic [15:0]   h2
);

  localparam int PW = $clog2(DEPTH_HW);

  logic [15:0]   slots [DEPTH_HW];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [1:0]    push_n, pop_n;

  always_comb begin
    push_n = push_en ? (push_skip_lo ? 2'd1 : 2'd2) : 2'd0;
    pop_n  = pop_en ? pop_hw : 2'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      for (int i = 0; i < DEPTH_HW; i++) slots[i] <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_en) begin
        if (push_skip_lo) begin
          slots[wr_ptr] <= push_data[31:16];
        end else begin
          slots[wr_ptr]          <= push_data[15:0];
          slots[wr_ptr + PW'(1)] <= push_data[31:16];
        end
      end
      wr_ptr <= wr_ptr + PW'(push_n);
      rd_ptr <= rd_ptr + PW'(pop_n);
      count  <= count + CW'(push_n) - CW'(pop_n);
    end
  end

  assign h0 = slots[rd_ptr];
  assign h1 = slots[rd_ptr + PW'(1)];
  assign h2 = slots[rd_ptr + PW'(2)];

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH_HW));

  assert_pop_within_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && !flush) |-> (CW'(pop_hw) <= count));

endmodule

// File: rtl/ipq_fetch_ctrl.sv
module ipq_fetch_ctrl #(
  parameter int AW       = 32,
  parameter int DEPTH_HW = 8,
  parameter int MAX_OUT  = 4,
  parameter int CW       = $clog2(DEPTH_HW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:1] start_hw,
  input  logic          redirect,
  input  logic [AW-1:1] target_hw,
  input  logic [CW-1:0] buf_count,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  input  logic          rsp_valid,
  output logic          rsp_accept,
  output logic          rsp_skip_lo
);

  localparam int OW = $clog2(MAX_OUT + 1);
  localparam int RW = $clog2(DEPTH_HW + 2 * MAX_OUT + 3) + 1;

  logic [AW-1:0] fetch_addr;
  logic [OW-1:0] out_cnt, stale_cnt, live_cnt;
  logic          skip_pending;
  logic [RW-1:0] reserved;
  logic          room_ok, req_fire, rsp_stale;

  always_comb begin
    live_cnt    = out_cnt - stale_cnt;
    reserved    = RW'(buf_count) + (RW'(live_cnt) << 1);
    room_ok     = (reserved + RW'(2)) <= RW'(DEPTH_HW);
    req_valid   = !redirect && room_ok && (out_cnt < OW'(MAX_OUT));
    req_fire    = req_valid && req_ready;
    rsp_stale   = (stale_cnt != '0);
    rsp_accept  = rsp_valid && !rsp_stale && !redirect;
    rsp_skip_lo = skip_pending;
  end

  assign req_addr = fetch_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_addr   <= {start_hw[AW-1:2], 2'b00};
      skip_pending <= start_hw[1];
      out_cnt      <= '0;
      stale_cnt    <= '0;
    end else if (redirect) begin
      fetch_addr   <= {target_hw[AW-1:2], 2'b00};
      skip_pending <= target_hw[1];
      out_cnt      <= out_cnt - OW'(rsp_valid);
      stale_cnt    <= out_cnt - OW'(rsp_valid);
    end else begin
      if (req_fire) fetch_addr <= fetch_addr + AW'(4);
      out_cnt <= out_cnt + OW'(req_fire) - OW'(rsp_valid);
      if (rsp_valid && rsp_stale) stale_cnt <= stale_cnt - OW'(1);
      if (rsp_accept) skip_pending <= 1'b0;
    end
  end

  assert_req_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (redirect || (req_valid && $stable(req_addr))));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> (req_addr == $past(req_addr) + AW'(4)));

  assert_reservation_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reserved <= RW'(DEPTH_HW));

  assert_stale_within_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stale_cnt <= out_cnt);

  assert_rsp_matches_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (out_cnt != '0));

endmodule

// File: rtl/insn_prefetch_queue.sv
module insn_prefetch_queue
  import ipq_pkg::*;
#(
  parameter int AW          = 32,
  parameter int QUEUE_BYTES = 16,
  parameter int MAX_OUT     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reset_vector,
  input  logic          redirect_valid,
  input  logic [AW-1:0] redirect_addr,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  output logic          dec_valid,
  input  logic          dec_ready,
  output logic [47:0]   dec_insn,
  output logic [1:0]    dec_len,
  output logic [AW-1:0] dec_pc
);

  localparam int DEPTH_HW = QUEUE_BYTES / 2;
  localparam int CW       = $clog2(DEPTH_HW + 1);

  logic [CW-1:0] hw_count;
  logic [15:0]   h0, h1, h2;
  logic [1:0]    need;
  logic          push_en, skip_lo, consume;
  logic [AW-1:0] pc_q;

  ipq_fetch_ctrl #(
    .AW(AW), .DEPTH_HW(DEPTH_HW), .MAX_OUT(MAX_OUT), .CW(CW)
  ) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_hw    (reset_vector[AW-1:1]),
    .redirect    (redirect_valid),
    .target_hw   (redirect_addr[AW-1:1]),
    .buf_count   (hw_count),
    .req_valid   (mem_req_valid),
    .req_ready   (mem_req_ready),
    .req_addr    (mem_req_addr),
    .rsp_valid   (mem_rsp_valid),
    .rsp_accept  (push_en),
    .rsp_skip_lo (skip_lo)
  );

  ipq_hw_buffer #(
    .DEPTH_HW(DEPTH_HW), .CW(CW)
  ) u_buf (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (redirect_valid),
    .push_en      (push_en),
    .push_skip_lo (skip_lo),
    .push_data    (mem_rsp_data),
    .pop_en       (consume),
    .pop_hw       (need),
    .count        (hw_count),
    .h0           (h0),
    .h1           (h1),
    .h2           (h2)
  );

  ipq_len_decode #(
    .CW(CW)
  ) u_len (
    .h0    (h0),
    .h1    (h1),
    .h2    (h2),
    .avail (hw_count),
    .len   (dec_len),
    .need  (need),
    .insn  (dec_insn),
    .valid (dec_valid)
  );

  assign consume = dec_valid && dec_ready && !redirect_valid;

  always_ff @(posedge clk) begin
    if (!rst_n)              pc_q <= reset_vector & ~AW'(1);
    else if (redirect_valid) pc_q <= redirect_addr & ~AW'(1);
    else if (consume)        pc_q <= pc_q + AW'({need, 1'b0});
  end

  assign dec_pc = pc_q;

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !dec_valid);

  assert_len_code_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_len != 2'b11));

endmodule

// File: tb/insn_prefetch_queue_tb.sv
module insn_prefetch_queue_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int AW         = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] reset_vector = 32'h100;
  logic          redirect_valid = 1'b0;
  logic [AW-1:0] redirect_addr = '0;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [31:0]   mem_rsp_data = '0;
  logic          dec_valid;
  logic          dec_ready = 1'b0;
  logic [47:0]   dec_insn;
  logic [1:0]    dec_len;
  logic [AW-1:0] dec_pc;

  insn_prefetch_queue #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reset_vector(reset_vector),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_insn(dec_insn), .dec_len(dec_len), .dec_pc(dec_pc)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit m16 = 1'b1;
  int ws = 0, lat = 1;
  int acc_count = 0, bubbles = 0;
  bit redir_since = 1'b1, want_first = 1'b0;
  string acc_tag = "R1";
  logic [31:0] exp_target = 32'h100, last_acc = '0, first_pc = '0;
  bit stall_prev = 1'b0;
  logic [31:0] stall_addr = '0;

  logic [31:0] pend_addr[$];
  int          pend_due[$];
  logic [31:0] exp_pc[$];
  logic [1:0]  exp_len[$];
  logic [47:0] exp_insn[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Memory image: the halfword at a byte address, with a mixed or all-16-bit length mix.
  function automatic logic [15:0] hw_at(input logic [31:0] a, input bit all16);
    logic [31:0] i;
    i = a >> 1;
    if (all16) return {2'b00, i[13:0]};
    case (i % 32'd5)
      32'd0:   return {2'b00,  i[13:0]};
      32'd1:   return {3'b110, i[12:0]};
      32'd2:   return {2'b10,  i[13:0]};
      32'd3:   return {3'b111, i[12:0]};
      default: return {2'b01,  i[13:0]};
    endcase
  endfunction

  // Driver side of the scoreboard: walk the image from a start address using the length rule.
  task automatic push_expect(input logic [31:0] start, input int n);
    logic [31:0] a;
    logic [15:0] f;
    int span;
    a = start & ~32'h1;
    exp_pc.delete(); exp_len.delete(); exp_insn.delete();
    for (int k = 0; k < n; k++) begin
      f = hw_at(a, m16);
      if (f[15:14] != 2'b11) begin span = 1; exp_len.push_back(2'd0); end
      else if (!f[13])       begin span = 2; exp_len.push_back(2'd1); end
      else                   begin span = 3; exp_len.push_back(2'd2); end
      exp_pc.push_back(a);
      exp_insn.push_back({f, (span >= 2) ? hw_at(a + 2, m16) : 16'h0,
                             (span == 3) ? hw_at(a + 4, m16) : 16'h0});
      a = a + 32'(2 * span);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      check(1'b0, "watchdog", "cycles", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Memory model and decoder monitor.
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (rst_n && pend_addr.size() != 0 && pend_due[0] <= cyc) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = {hw_at(pend_addr[0] + 2, m16), hw_at(pend_addr[0], m16)};
      void'(pend_addr.pop_front());
      void'(pend_due.pop_front());
    end
    mem_req_ready = (ws == 0) || ((cyc % (ws + 1)) == 0);
    #1;
    if (rst_n) begin
      if (stall_prev && !redirect_valid)
        check(mem_req_valid && mem_req_addr == stall_addr, "R3", "held request addr",
              mem_req_addr, stall_addr);
      stall_prev = mem_req_valid && !mem_req_ready;
      stall_addr = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        if (redir_since) begin
          check(mem_req_addr == exp_target, acc_tag, "first request addr", mem_req_addr, exp_target);
          redir_since = 1'b0;
        end else begin
          check(mem_req_addr == last_acc + 4, "R2", "sequential request addr",
                mem_req_addr, last_acc + 4);
        end
        last_acc = mem_req_addr;
        acc_count++;
        pend_addr.push_back(mem_req_addr);
        pend_due.push_back(cyc + lat);
      end
      if (!redirect_valid && dec_ready) begin
        if (!dec_valid) bubbles++;
        else if (exp_pc.size() == 0) check(1'b0, "R7", "scoreboard empty", 0, 1);
        else begin
          check(dec_pc == exp_pc[0], "R7", "dec_pc", dec_pc, exp_pc[0]);
          check(dec_len == exp_len[0], "R5", "dec_len", dec_len, exp_len[0]);
          check(dec_insn == exp_insn[0], "R4,R6", "dec_insn", dec_insn, exp_insn[0]);
          if (want_first) begin first_pc = dec_pc; want_first = 1'b0; end
          void'(exp_pc.pop_front()); void'(exp_len.pop_front()); void'(exp_insn.pop_front());
        end
      end
    end
  end

  task automatic do_redirect(input logic [31:0] tgt, input bit all16);
    @(negedge clk);
    m16 = all16;
    redirect_valid = 1'b1;
    redirect_addr  = tgt;
    push_expect(tgt, 300);
    redir_since = 1'b1;
    acc_tag     = "R8";
    exp_target  = tgt & ~32'h3;
    want_first  = 1'b1;
    @(negedge clk);
    redirect_valid = 1'b0;
    #2;
    check(!dec_valid, "R8", "dec_valid after redirect", dec_valid, 0);
    check(dec_pc == (tgt & ~32'h1), "R8", "dec_pc after redirect", dec_pc, tgt & ~32'h1);
  endtask

  task automatic consume_one();
    @(negedge clk); dec_ready = 1'b1;
    @(negedge clk); dec_ready = 1'b0;
  endtask

  initial begin
    push_expect(32'h100, 300);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(!dec_valid, "R1", "dec_valid at reset", dec_valid, 0);
    check(dec_pc == 32'h100, "R1", "dec_pc at reset", dec_pc, 32'h100);

    // Capacity: no consumption, always-ready memory.
    repeat (20) @(negedge clk);
    #2;
    check(acc_count == 4, "R11", "requests with full queue", acc_count, 4);
    check(dec_valid == 1'b1, "R6", "dec_valid with data", dec_valid, 1);
    consume_one();
    repeat (10) @(negedge clk);
    check(acc_count == 4, "R2", "requests with 2 free bytes", acc_count, 4);
    consume_one();
    repeat (10) @(negedge clk);
    check(acc_count == 5, "R2", "requests with 4 free bytes", acc_count, 5);

    // Zero-wait streaming of 16-bit instructions.
    dec_ready = 1'b1;
    repeat (10) @(negedge clk);
    bubbles = 0;
    repeat (40) @(negedge clk);
    check(bubbles == 0, "R12", "bubbles in zero-wait stream", bubbles, 0);

    // Mixed lengths with one wait state and longer latency.
    ws = 1; lat = 2;
    do_redirect(32'h200, 1'b0);
    repeat (80) @(negedge clk);
    check(first_pc == 32'h200, "R8", "first pc after redirect", first_pc, 32'h200);

    // Misaligned target with several requests in flight.
    ws = 0; lat = 4;
    do_redirect(32'h302, 1'b0);
    for (int k = 0; k < 90; k++) begin
      @(negedge clk);
      dec_ready = (k % 3) != 0;
    end
    check(first_pc == 32'h302, "R9,R10", "first pc after misaligned flush", first_pc, 32'h302);

    ws = 2; lat = 1;
    dec_ready = 1'b1;
    do_redirect(32'h40A, 1'b0);
    repeat (80) @(negedge clk);
    check(first_pc == 32'h40A, "R10", "first pc misaligned target", first_pc, 32'h40A);

    // Back-to-back redirects: the last one wins.
    ws = 0; lat = 3;
    do_redirect(32'h500, 1'b0);
    do_redirect(32'h606, 1'b0);
    repeat (60) @(negedge clk);
    check(first_pc == 32'h606, "R8", "first pc after double redirect", first_pc, 32'h606);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule